// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block loads a configuration image into an SRAM-based FPGA over that target's slave SPI port. A single start pulse runs the whole sequence. The target is held in reset with its chip-select asserted. After reset is released, the target's done flag must read low. Chip-select stays low for a long housekeeping interval and is then released. The image is then clocked out MSB-first on a mode-0 link (clock idles low, data sampled on the rising edge).

Image bytes come from a valid/ready byte stream whose final byte carries an end marker. A byte is taken only when the serialiser is empty, so the source may stall at any point. After the last byte, the synchronised done flag must read high. The block then sends seven zero bytes, 56 clocks that cover the 49 the target needs, to start the loaded design. Busy, done and error outputs report the outcome, and a 3-bit code names the failure.

Top module: `fpga_cfg_loader`

## Requirements
- R1: A start with `partial_req` high ends with `cfg_err` high and `cfg_err_code` = 1. `tgt_rst_n` and `spi_cs_n` never leave their high level.
- R2: A start whose `sck_half_div` (SPI half-period in system clocks) gives a rate above 25 MHz or below 1 MHz is rejected with `cfg_err_code` = 2, and the target is not touched. With a 250 MHz system clock the accepted window is 5..125.
- R3: An accepted start drives `tgt_rst_n` low for exactly RST_CYC system clocks, and `spi_cs_n` is low for that whole time.
- R4: If the synchronised done input reads high after reset release, the load aborts with `cfg_err_code` = 3. No image byte is accepted and no SPI clock is sent.
- R5: `spi_cs_n` stays low from reset assertion through 3 settle cycles and HK_CYC housekeeping cycles, that is RST_CYC+3+HK_CYC clocks in total. It then rises before any image data is clocked.
- R6: Image bytes appear on `spi_mosi` MSB-first in mode 0, so each bit is valid at a rising `spi_sck`. `spi_sck` is low whenever `spi_cs_n` is high. The byte sequence is reproduced exactly under arbitrary stalls of `img_valid`.
- R7: If done reads low after the last image byte, the load ends with `cfg_err_code` = 4 and no activation bytes are sent.
- R8: On success, exactly 7 zero bytes follow the image, then `cfg_done` is high with `cfg_err` low and code 0.
- R9: `cfg_busy` is high from an accepted start until done or error is posted, never together with either. A start while busy is ignored.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (pulse) |
| partial_req | input | 1 | Request is partial reconfiguration (unsupported) |
| sck_half_div | input | DIV_W | SPI half-period in system clocks, sampled at start |
| img_data | input | 8 | Image byte |
| img_valid | input | 1 | Image byte valid |
| img_last | input | 1 | Marks the final image byte |
| img_ready | output | 1 | Byte accepted when high with img_valid |
| tgt_rst_n | output | 1 | Active-low target reset |
| spi_cs_n | output | 1 | Active-low SPI chip-select |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | SPI data to target |
| tgt_done | input | 1 | Target done status (asynchronous) |
| cfg_busy | output | 1 | Load in progress |
| cfg_done | output | 1 | Load succeeded (held until next start) |
| cfg_err | output | 1 | Load failed (held until next start) |
| cfg_err_code | output | 3 | 0 none, 1 partial, 2 rate, 3 reset check, 4 load check |

## Verification
Rejections by partial flag or rate are posted on the clock edge that samples start, so the bench reads them at the next falling edge. Reset width and chip-select span are due RST_CYC and RST_CYC+3+HK_CYC clocks after start, and the bench counts them at falling edges rather than predicting single edges. Each data byte needs 16 half-periods, and the done checks fall 3 clocks after reset release or after the last byte. For these results the bench waits at falling edges for busy to drop with a status set, and only then compares the captured SPI bytes, counts and code against its own model.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RESET, ST_SETTLE, ST_HOUSE, ST_GAP, ST_STREAM, ST_VERIFY, ST_PAD
    } cfg_state_e;

    typedef enum logic [2:0] {
        CFG_OK          = 3'd0,
        CFG_ERR_PARTIAL = 3'd1,
        CFG_ERR_RATE    = 3'd2,
        CFG_ERR_RESET   = 3'd3,
        CFG_ERR_LOAD    = 3'd4
    } cfg_err_e;

    localparam int unsigned ACT_BITS  = 49;
    localparam int unsigned PAD_BYTES = (ACT_BITS + 7) / 8;
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cfgld_shift.sv
module cfgld_shift #(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned BITS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             load,
    input  logic [BITS-1:0]  din,
    output logic             sck,
    output logic             mosi,
    output logic             idle
);
    localparam int unsigned LW = $clog2(BITS + 1);

    typedef struct packed {
        logic [BITS-1:0]  sr;
        logic [LW-1:0]    left;
        logic             sck;
        logic [DIV_W-1:0] cnt;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (sh_q.left == '0) begin
            if (load) begin
                sh_d.sr   = din;
                sh_d.left = LW'(BITS);
                sh_d.sck  = 1'b0;
                sh_d.cnt  = '0;
            end
        end else if (sh_q.cnt == DIV_W'(half_div - 1'b1)) begin
            sh_d.cnt = '0;
            if (!sh_q.sck) begin
                sh_d.sck = 1'b1;
            end else begin
                sh_d.sck  = 1'b0;
                sh_d.sr   = {sh_q.sr[BITS-2:0], 1'b0};
                sh_d.left = sh_q.left - 1'b1;
            end
        end else begin
            sh_d.cnt = sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sck  = sh_q.sck;
    assign mosi = sh_q.sr[BITS-1];
    assign idle = (sh_q.left == '0);
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ  = 250_000_000,
    parameter int unsigned SCK_MAX_HZ  = 25_000_000,
    parameter int unsigned SCK_MIN_HZ  = 1_000_000,
    parameter int unsigned RST_CYC     = 250,
    parameter int unsigned HK_CYC      = 300_000,
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             partial_req,
    input  logic [DIV_W-1:0] sck_half_div,
    input  logic [7:0]       img_data,
    input  logic             img_valid,
    input  logic             img_last,
    output logic             img_ready,
    output logic             tgt_rst_n,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             tgt_done,
    output logic             cfg_busy,
    output logic             cfg_done,
    output logic             cfg_err,
    output logic [2:0]       cfg_err_code
);
    localparam int unsigned MIN_HALF   = (SYS_CLK_HZ + 2*SCK_MAX_HZ - 1) / (2*SCK_MAX_HZ);
    localparam int unsigned MAX_HALF   = SYS_CLK_HZ / (2*SCK_MIN_HZ);
    localparam int unsigned SETTLE_CYC = SYNC_STAGES + 1;
    localparam int unsigned CNT_MAX    = (RST_CYC > HK_CYC) ? RST_CYC : HK_CYC;
    localparam int unsigned CW         = $clog2(CNT_MAX + SETTLE_CYC + 1);
    localparam int unsigned PW         = $clog2(PAD_BYTES + 1);

    typedef struct packed {
        cfg_state_e       state;
        logic [CW-1:0]    cnt;
        logic [DIV_W-1:0] div;
        logic             last_seen;
        logic [PW-1:0]    pad_left;
        logic             done;
        logic             err;
        cfg_err_e         code;
    } ctl_t;

    ctl_t       c_d, c_q;
    logic       done_s;
    logic       sh_load;
    logic [7:0] sh_din;
    logic       sh_idle;

    cfgld_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(tgt_done), .q(done_s)
    );

    cfgld_shift #(.DIV_W(DIV_W), .BITS(8)) u_shift (
        .clk(clk), .rst_n(rst_n), .half_div(c_q.div), .load(sh_load),
        .din(sh_din), .sck(spi_sck), .mosi(spi_mosi), .idle(sh_idle)
    );

    always_comb begin
        c_d       = c_q;
        sh_load   = 1'b0;
        sh_din    = 8'h00;
        img_ready = 1'b0;
        case (c_q.state)
            ST_IDLE: if (start) begin
                c_d.done = 1'b0;
                c_d.err  = 1'b0;
                c_d.code = CFG_OK;
                if (partial_req) begin
                    c_d.err  = 1'b1;
                    c_d.code = CFG_ERR_PARTIAL;
                end else if (32'(sck_half_div) < MIN_HALF || 32'(sck_half_div) > MAX_HALF) begin
                    c_d.err  = 1'b1;
                    c_d.code = CFG_ERR_RATE;
                end else begin
                    c_d.state     = ST_RESET;
                    c_d.cnt       = '0;
                    c_d.div       = sck_half_div;
                    c_d.last_seen = 1'b0;
                end
            end
            ST_RESET: begin
                c_d.cnt = c_q.cnt + 1'b1;
                if (c_q.cnt == CW'(RST_CYC - 1)) begin
                    c_d.state = ST_SETTLE;
                    c_d.cnt   = '0;
                end
            end
            ST_SETTLE: begin
                c_d.cnt = c_q.cnt + 1'b1;
                if (c_q.cnt == CW'(SETTLE_CYC - 1)) begin
                    c_d.cnt = '0;
                    if (done_s) begin
                        c_d.state = ST_IDLE;
                        c_d.err   = 1'b1;
                        c_d.code  = CFG_ERR_RESET;
                    end else begin
                        c_d.state = ST_HOUSE;
                    end
                end
            end
            ST_HOUSE: begin
                c_d.cnt = c_q.cnt + 1'b1;
                if (c_q.cnt == CW'(HK_CYC - 1)) begin
                    c_d.state = ST_GAP;
                    c_d.cnt   = '0;
                end
            end
            ST_GAP: c_d.state = ST_STREAM;
            ST_STREAM: begin
                img_ready = sh_idle && !c_q.last_seen;
                if (img_valid && img_ready) begin
                    sh_load       = 1'b1;
                    sh_din        = img_data;
                    c_d.last_seen = img_last;
                end
                if (sh_idle && c_q.last_seen) begin
                    c_d.state = ST_VERIFY;
                    c_d.cnt   = '0;
                end
            end
            ST_VERIFY: begin
                c_d.cnt = c_q.cnt + 1'b1;
                if (c_q.cnt == CW'(SETTLE_CYC - 1)) begin
                    c_d.cnt = '0;
                    if (done_s) begin
                        c_d.state    = ST_PAD;
                        c_d.pad_left = PW'(PAD_BYTES);
                    end else begin
                        c_d.state = ST_IDLE;
                        c_d.err   = 1'b1;
                        c_d.code  = CFG_ERR_LOAD;
                    end
                end
            end
            ST_PAD: if (sh_idle) begin
                if (c_q.pad_left == '0) begin
                    c_d.state = ST_IDLE;
                    c_d.done  = 1'b1;
                end else begin
                    sh_load      = 1'b1;
                    c_d.pad_left = c_q.pad_left - 1'b1;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
            c_q.code  <= CFG_OK;
        end else begin
            c_q <= c_d;
        end
    end

    assign tgt_rst_n    = (c_q.state != ST_RESET);
    assign spi_cs_n     = !(c_q.state inside {ST_RESET, ST_SETTLE, ST_HOUSE, ST_STREAM, ST_PAD});
    assign cfg_busy     = (c_q.state != ST_IDLE);
    assign cfg_done     = c_q.done;
    assign cfg_err      = c_q.err;
    assign cfg_err_code = c_q.code;
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
    parameter int unsigned RST_CYC = 250
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tgt_rst_n,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic       spi_mosi,
    input logic       img_ready,
    input logic       cfg_busy,
    input logic       cfg_done,
    input logic       cfg_err,
    input logic [2:0] cfg_err_code
);
    logic [31:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          low_run_q <= '0;
        else if (!tgt_rst_n) low_run_q <= low_run_q + 1;
        else                 low_run_q <= '0;
    end

    // R3: chip-select accompanies target reset
    a_r3_cs_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_rst_n |-> !spi_cs_n);

    // R3: reset pulse width counted in the checker
    a_r3_reset_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_rst_n) |-> (low_run_q == RST_CYC));

    // R6: clock idles low while deselected
    a_r6_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R6: data holds steady across the sampling edge
    a_r6_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> $stable(spi_mosi));

    // R9: busy never overlaps a posted status
    a_r9_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_busy |-> (!cfg_done && !cfg_err));

    // R8: success carries a clean code
    a_r8_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> (!cfg_err && cfg_err_code == 3'd0));

    // R1: rejected requests leave the target lines high
    a_r1_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && cfg_err_code inside {3'd1, 3'd2}) |-> (tgt_rst_n && spi_cs_n));

    // R4: no image handshake outside an active load
    a_r4_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready |-> cfg_busy);
endmodule

bind fpga_cfg_loader cfgld_chk #(.RST_CYC(RST_CYC)) u_cfgld_chk (
    .clk(clk), .rst_n(rst_n), .tgt_rst_n(tgt_rst_n), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .img_ready(img_ready),
    .cfg_busy(cfg_busy), .cfg_done(cfg_done), .cfg_err(cfg_err),
    .cfg_err_code(cfg_err_code)
);

// File: tb/fpga_cfg_loader_test.sv
module fpga_cfg_loader_test;
    localparam int RST_CYC = 8;
    localparam int HK_CYC  = 40;
    localparam int MIN_H   = 5;
    localparam int MAX_H   = 125;

    logic clk = 0, rst_n = 0;
    logic start = 0, partial_req = 0;
    logic [7:0] sck_half_div = 8'd5;
    logic [7:0] img_data = 0;
    logic img_valid = 0, img_last = 0, img_ready;
    logic tgt_rst_n, spi_cs_n, spi_sck, spi_mosi;
    logic tgt_done = 0;
    logic cfg_busy, cfg_done, cfg_err;
    logic [2:0] cfg_err_code;

    always #2 clk = ~clk;

    fpga_cfg_loader #(.RST_CYC(RST_CYC), .HK_CYC(HK_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .partial_req(partial_req),
        .sck_half_div(sck_half_div), .img_data(img_data), .img_valid(img_valid),
        .img_last(img_last), .img_ready(img_ready), .tgt_rst_n(tgt_rst_n),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .tgt_done(tgt_done), .cfg_busy(cfg_busy), .cfg_done(cfg_done),
        .cfg_err(cfg_err), .cfg_err_code(cfg_err_code)
    );

    int n_run = 0, n_fail = 0, cyc = 0;
    logic [7:0] img [16];
    logic [7:0] rx [32];
    int rx_cnt, bitc, rst_low, cs_run, cs_run0, hs, done_mode, n_img;
    bit got0, touched, stop_drv;
    logic [7:0] rx_sh;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input bit part, input int half, input int dm);
        if (part) return 1;
        if (half < MIN_H || half > MAX_H) return 2;
        if (dm == 1) return 3;
        if (dm == 0) return 4;
        return 0;
    endfunction

    // SPI receiver model: mode 0, MSB first
    always @(posedge spi_sck) if (!spi_cs_n) begin
        rx_sh = {rx_sh[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            if (rx_cnt < 32) rx[rx_cnt] = rx_sh;
            rx_cnt++;
            bitc = 0;
            if (done_mode == 2 && rx_cnt >= n_img) tgt_done = 1;
        end
    end

    always @(negedge clk) begin
        if (!spi_cs_n || !tgt_rst_n) touched = 1;
        if (!tgt_rst_n) rst_low++;
        if (!spi_cs_n) cs_run++;
        else if (cs_run != 0) begin
            if (!got0) cs_run0 = cs_run;
            got0 = 1;
            cs_run = 0;
        end
        if (img_valid && img_ready) hs++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic drive_stream(input int n);
        for (int i = 0; i < n && !stop_drv; i++) begin
            int gap = $urandom % 4;
            for (int g = 0; g < gap; g++) @(negedge clk);
            img_data = img[i]; img_last = (i == n - 1); img_valid = 1;
            while (!stop_drv) begin
                if (img_ready) begin @(negedge clk); break; end
                @(negedge clk);
            end
            img_valid = 0; img_last = 0;
        end
    endtask

    task automatic run_load(input bit part, input int half, input int dm,
                            input int n, input bit inject, input string tag);
        int code, bad;
        code = exp_code(part, half, dm);
        for (int i = 0; i < n; i++) img[i] = 8'($urandom);
        @(posedge clk);
        rx_cnt = 0; bitc = 0; rst_low = 0; cs_run = 0; cs_run0 = 0; got0 = 0;
        touched = 0; hs = 0; stop_drv = 0; done_mode = dm; n_img = n;
        tgt_done = (dm == 1);
        @(negedge clk);
        partial_req = part; sck_half_div = 8'(half); start = 1;
        @(negedge clk);
        start = 0;
        fork
            drive_stream(n);
            if (inject) begin
                for (int k = 0; k < 4; k++) @(negedge clk);
                partial_req = 1; start = 1;
                @(negedge clk);
                start = 0; partial_req = part;
            end
            begin
                while (!((cfg_done || cfg_err) && !cfg_busy)) @(negedge clk);
                stop_drv = 1;
            end
        join
        // R1 R2 R4 R7 R8: outcome code
        check(int'(cfg_err_code) == code, {"R8/R7/R4/R2/R1 code ", tag}, cfg_err_code, code);
        check(cfg_done == (code == 0) && cfg_err == (code != 0),
              {"R9 status flags ", tag}, {cfg_done, cfg_err}, (code == 0) ? 2 : 1);
        if (code == 1 || code == 2)
            check(!touched && rst_low == 0, {"R1/R2 target untouched ", tag}, touched, 0);
        else begin
            check(rst_low == RST_CYC, {"R3 reset width ", tag}, rst_low, RST_CYC);
            check(cs_run0 == ((code == 3) ? RST_CYC + 3 : RST_CYC + 3 + HK_CYC),
                  {"R5 cs span ", tag}, cs_run0, (code == 3) ? RST_CYC + 3 : RST_CYC + 3 + HK_CYC);
        end
        if (code == 0 || code == 4) begin
            bad = 0;
            for (int i = 0; i < n; i++) if (rx[i] !== img[i]) bad++;
            check(bad == 0 && hs == n, {"R6 image bytes ", tag}, bad, 0);
        end
        if (code == 0) begin
            bad = 0;
            for (int i = n; i < n + 7; i++) if (rx[i] !== 8'h00) bad++;
            check(rx_cnt == n + 7 && bad == 0, {"R8 activation bytes ", tag}, rx_cnt, n + 7);
        end
        if (code == 4) check(rx_cnt == n, {"R7 no padding ", tag}, rx_cnt, n);
        if (code == 3) check(rx_cnt == 0 && hs == 0, {"R4 nothing sent ", tag}, rx_cnt + hs, 0);
        tgt_done = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!cfg_busy && !cfg_done && !cfg_err && tgt_rst_n && spi_cs_n && !spi_sck,
              "R9 reset state", {cfg_busy, cfg_done, cfg_err}, 0);
        run_load(0, 5,   2, 4, 0, "nominal");
        run_load(0, 125, 2, 2, 0, "slowest rate");
        run_load(0, 4,   2, 3, 0, "rate too fast");
        run_load(0, 126, 2, 3, 0, "rate too slow");
        run_load(0, 0,   2, 3, 0, "zero divider");
        run_load(1, 6,   2, 3, 0, "partial");
        run_load(0, 6,   1, 3, 0, "done stuck high");
        run_load(0, 6,   0, 3, 0, "done never high");
        run_load(0, 7,   2, 5, 1, "start while busy R9");
        run_load(0, 5,   2, 1, 0, "single byte");
        for (int r = 0; r < 8; r++) begin
            int half = 5 + ($urandom % 8);
            int dm   = (($urandom % 5) == 0) ? int'($urandom % 2) : 2;
            bit part = (($urandom % 8) == 0);
            if (($urandom % 6) == 0) half = ($urandom % 2) ? 4 : 126;
            run_load(part, half, dm, 1 + ($urandom % 8), 0, "random");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule